// File: doc/BRIEF.md
# Interrupt Dispatch and Return Sequencer

This block is the part of a small 8-bit processor core that takes over the register file when an interrupt has to be entered or left. When an instruction reaches its boundary while an interrupt request is pending and interrupts are globally enabled, the sequencer runs a fixed-length entry routine. It saves the program counter and the flag byte on a byte-wide stack, clears the flags, which also turns the global interrupt enable off, and points the program counter at the interrupt-table entry whose low byte comes from the interrupt controller.

The matching return routine starts when the instruction reaching its boundary is a return-from-interrupt. It pops the flag byte and both program-counter bytes, writes them back and restores the stack pointer. If a request is still pending and the restored flags allow it, the sequencer goes straight into a new entry routine, so no ordinary instruction runs in between. The processor's registers and the stack memory stay outside the block. The sequencer reads them on its input ports and writes them through write strobes. The stack memory has one cycle of read latency.

Top module: `irq_dispatch_seq`

## Requirements
- R1: An entry routine starts only from idle, in a cycle where `insn_done` is high, `irq_req` is high, `reti_req` is low and flag bit 0 (global enable) of `flags_i` is set. `busy` rises on the next clock edge.
- R2: Counting the first cycle after the start edge as cycle 1, `done` pulses in cycle 13 of the entry routine. In that same cycle `pc_we` writes the new program counter, and the block then returns to idle.
- R3: In cycles 1, 2 and 3 the routine writes the program counter high byte, then the low byte, then the flags, to stack addresses SP, SP+1 and SP+2 (modulo 256). After each write the stack pointer is written with its incremented value, ending at SP+3.
- R4: In cycle 4 the flag register is written with zero, which clears the global enable.
- R5: `irq_ack` is a single pulse in cycle 12, and `irq_vec` is sampled in that cycle. In cycle 13 the program counter becomes {8'h00, sampled vector}.
- R6: A return starts from idle when `insn_done` and `reti_req` are high together. In cycles 1 to 3 it reads addresses SP-1, SP-2 and SP-3 (flags, PC low, PC high), with the data arriving one cycle later. In cycle 4 it writes PC, flags and SP-3 and pulses `ret_done`.
- R7: When `reti_req` and a qualified interrupt request meet at the same boundary, the return runs first.
- R8: If `irq_req` is high at the end of a return and bit 0 of the restored flags is set, an entry routine starts on the next clock edge with no idle cycle. It pushes the restored PC and flags.
- R9: While a routine runs, `insn_done`, `reti_req` and `irq_req` have no effect on its length. While idle with global enable clear, an interrupt request does not start anything.
- R10: After reset the block is idle, with `busy`, all write, read, acknowledge and done strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_done | input | 1 | Current instruction reaches its boundary this cycle |
| reti_req | input | 1 | The instruction at this boundary is a return-from-interrupt |
| irq_req | input | 1 | Interrupt pending from the controller |
| irq_vec | input | 8 | Interrupt-table low byte from the controller |
| pc_i | input | 16 | Current program counter |
| flags_i | input | 8 | Current flag register, bit 0 is the global enable |
| sp_i | input | 8 | Current stack pointer |
| stk_rdata | input | 8 | Stack read data, valid the cycle after a read |
| busy | output | 1 | A routine is in progress |
| irq_ack | output | 1 | Vector sampled, acknowledge to the controller |
| done | output | 1 | Last cycle of the entry routine |
| ret_done | output | 1 | Last cycle of the return routine |
| pc_we | output | 1 | Program counter write strobe |
| pc_o | output | 16 | Program counter write value |
| flags_we | output | 1 | Flag register write strobe |
| flags_o | output | 8 | Flag register write value |
| sp_we | output | 1 | Stack pointer write strobe |
| sp_o | output | 8 | Stack pointer write value |
| stk_we | output | 1 | Stack write strobe |
| stk_re | output | 1 | Stack read strobe |
| stk_addr | output | 8 | Stack address |
| stk_wdata | output | 8 | Stack write data |

## Verification
On every cycle, the assertions watch the entry length against an independent cycle counter, the address step between consecutive pushes, the flag clear right after the last push, the acknowledge pulse leading the final PC load, and the gating of starts by the boundary strobe, the global enable and the return priority. The byte contents that actually land on the stack and come back through the read latency, the stack pointer wrapping past 255, and a return chaining into a fresh entry with the restored context can only be shown by the bench. It runs these scenarios against a model of the register file and the stack memory.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DISP = 2'd1,
    ST_RET  = 2'd2
  } seq_state_e;

  // bytes saved per interrupt frame, and length of the return routine
  localparam int FRAME_BYTES = 3;
  localparam int RET_STEPS   = 4;
endpackage

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
#(
  parameter int DISP_CYC = 13,
  parameter int SW       = $clog2(DISP_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          insn_done,
  input  logic          reti_req,
  input  logic          irq_req,
  input  logic          gie_now,
  input  logic          gie_ret,
  output seq_state_e    state,
  output logic [SW-1:0] step,
  output logic          start_norm,
  output logic          start_ret,
  output logic          chain
);
  logic last_disp, last_ret;

  always_comb begin
    last_disp  = (state == ST_DISP) && (step == SW'(DISP_CYC));
    last_ret   = (state == ST_RET) && (step == SW'(RET_STEPS));
    start_ret  = (state == ST_IDLE) && insn_done && reti_req;
    start_norm = (state == ST_IDLE) && insn_done && !reti_req && irq_req && gie_now;
    chain      = last_ret && irq_req && gie_ret;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      step  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_ret) begin
            state <= ST_RET;
            step  <= SW'(1);
          end else if (start_norm) begin
            state <= ST_DISP;
            step  <= SW'(1);
          end
        end
        ST_DISP: begin
          if (last_disp) begin
            state <= ST_IDLE;
            step  <= '0;
          end else begin
            step <= step + SW'(1);
          end
        end
        ST_RET: begin
          if (chain) begin
            state <= ST_DISP;
            step  <= SW'(1);
          end else if (last_ret) begin
            state <= ST_IDLE;
            step  <= '0;
          end else begin
            step <= step + SW'(1);
          end
        end
        default: begin
          state <= ST_IDLE;
          step  <= '0;
        end
      endcase
    end
  end

  // R1: without a boundary strobe the idle state is kept
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) && !insn_done |=> (state == ST_IDLE));

  // R9: global enable clear blocks an interrupt request
  p_gie_block_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) && !gie_now && !reti_req |=> (state == ST_IDLE));

  // R7: a return at the boundary wins over a request
  p_ret_first_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) && insn_done && reti_req |=> (state == ST_RET));

  // R8: pending qualified request at return end goes straight to entry
  p_chain_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RET) && (step == SW'(RET_STEPS)) && irq_req && gie_ret
    |=> (state == ST_DISP) && (step == SW'(1)));

  // R9: a running routine keeps its kind until its last step
  p_no_restart_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DISP) && (step != SW'(DISP_CYC)) |=> (state == ST_DISP) && (step != SW'(1)));
endmodule

// File: rtl/irq_seq_snap.sv
module irq_seq_snap #(
  parameter int DW   = 8,
  parameter int SP_W = 8,
  parameter int PC_W = 2 * DW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_cpu,
  input  logic [PC_W-1:0] pc_i,
  input  logic [DW-1:0]   flags_i,
  input  logic [SP_W-1:0] sp_i,
  input  logic            cap_flags,
  input  logic            cap_pcl,
  input  logic            chain,
  input  logic [DW-1:0]   stk_rdata,
  input  logic            cap_vec,
  input  logic [DW-1:0]   irq_vec,
  output logic [PC_W-1:0] pc_q,
  output logic [DW-1:0]   flags_q,
  output logic [SP_W-1:0] sp_q,
  output logic [DW-1:0]   vec_q
);
  localparam int FRAME = irq_seq_pkg::FRAME_BYTES;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      flags_q <= '0;
      sp_q    <= '0;
      vec_q   <= '0;
    end else begin
      if (load_cpu) begin
        pc_q    <= pc_i;
        flags_q <= flags_i;
        sp_q    <= sp_i;
      end
      if (cap_flags) flags_q <= stk_rdata;
      if (cap_pcl) pc_q[DW-1:0] <= stk_rdata;
      if (chain) begin
        pc_q[PC_W-1:DW] <= stk_rdata;
        sp_q            <= sp_q - SP_W'(FRAME);
      end
      if (cap_vec) vec_q <= irq_vec;
    end
  end
endmodule

// File: rtl/irq_dispatch_seq.sv
module irq_dispatch_seq
  import irq_seq_pkg::*;
#(
  parameter int DW       = 8,
  parameter int SP_W     = 8,
  parameter int DISP_CYC = 13,
  parameter int GIE_BIT  = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               insn_done,
  input  logic               reti_req,
  input  logic               irq_req,
  input  logic [DW-1:0]      irq_vec,
  input  logic [2*DW-1:0]    pc_i,
  input  logic [DW-1:0]      flags_i,
  input  logic [SP_W-1:0]    sp_i,
  input  logic [DW-1:0]      stk_rdata,
  output logic               busy,
  output logic               irq_ack,
  output logic               done,
  output logic               ret_done,
  output logic               pc_we,
  output logic [2*DW-1:0]    pc_o,
  output logic               flags_we,
  output logic [DW-1:0]      flags_o,
  output logic               sp_we,
  output logic [SP_W-1:0]    sp_o,
  output logic               stk_we,
  output logic               stk_re,
  output logic [SP_W-1:0]    stk_addr,
  output logic [DW-1:0]      stk_wdata
);
  localparam int PC_W     = 2 * DW;
  localparam int SW       = $clog2(DISP_CYC + 1);
  localparam int VEC_STEP = DISP_CYC - 1;
  localparam int CLR_STEP = FRAME_BYTES + 1;

  seq_state_e      state;
  logic [SW-1:0]   step;
  logic            start_norm, start_ret, chain;
  logic [PC_W-1:0] pc_q;
  logic [DW-1:0]   flags_q, vec_q;
  logic [SP_W-1:0] sp_q;
  logic            in_disp, in_ret;

  assign in_disp = (state == ST_DISP);
  assign in_ret  = (state == ST_RET);

  irq_seq_fsm #(.DISP_CYC(DISP_CYC), .SW(SW)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .insn_done  (insn_done),
    .reti_req   (reti_req),
    .irq_req    (irq_req),
    .gie_now    (flags_i[GIE_BIT]),
    .gie_ret    (flags_q[GIE_BIT]),
    .state      (state),
    .step       (step),
    .start_norm (start_norm),
    .start_ret  (start_ret),
    .chain      (chain)
  );

  irq_seq_snap #(.DW(DW), .SP_W(SP_W), .PC_W(PC_W)) u_snap (
    .clk       (clk),
    .rst       (rst),
    .load_cpu  (start_norm | start_ret),
    .pc_i      (pc_i),
    .flags_i   (flags_i),
    .sp_i      (sp_i),
    .cap_flags (in_ret && (step == SW'(2))),
    .cap_pcl   (in_ret && (step == SW'(3))),
    .chain     (chain),
    .stk_rdata (stk_rdata),
    .cap_vec   (irq_ack),
    .irq_vec   (irq_vec),
    .pc_q      (pc_q),
    .flags_q   (flags_q),
    .sp_q      (sp_q),
    .vec_q     (vec_q)
  );

  always_comb begin
    busy      = (state != ST_IDLE);
    irq_ack   = in_disp && (step == SW'(VEC_STEP));
    done      = in_disp && (step == SW'(DISP_CYC));
    ret_done  = in_ret && (step == SW'(RET_STEPS));
    pc_we     = 1'b0;
    pc_o      = '0;
    flags_we  = 1'b0;
    flags_o   = '0;
    sp_we     = 1'b0;
    sp_o      = '0;
    stk_we    = 1'b0;
    stk_re    = 1'b0;
    stk_addr  = '0;
    stk_wdata = '0;

    // entry: push high, low, flags; clear flags; load vector
    if (in_disp && (step <= SW'(FRAME_BYTES))) begin
      stk_we   = 1'b1;
      stk_addr = sp_q + SP_W'(step - SW'(1));
      sp_we    = 1'b1;
      sp_o     = sp_q + SP_W'(step);
      if (step == SW'(1))      stk_wdata = pc_q[PC_W-1:DW];
      else if (step == SW'(2)) stk_wdata = pc_q[DW-1:0];
      else                     stk_wdata = flags_q;
    end
    if (in_disp && (step == SW'(CLR_STEP))) begin
      flags_we = 1'b1;
      flags_o  = '0;
    end
    if (done) begin
      pc_we = 1'b1;
      pc_o  = {{DW{1'b0}}, vec_q};
    end

    // return: pop flags, low, high; write back in the last step
    if (in_ret && (step <= SW'(FRAME_BYTES))) begin
      stk_re   = 1'b1;
      stk_addr = sp_q - SP_W'(step);
    end
    if (ret_done) begin
      pc_we    = 1'b1;
      pc_o     = {stk_rdata, pc_q[DW-1:0]};
      flags_we = 1'b1;
      flags_o  = flags_q;
      sp_we    = 1'b1;
      sp_o     = sp_q - SP_W'(FRAME_BYTES);
    end
  end

  // independent length counter for the entry routine
  logic [SW:0] chk_cnt;
  always_ff @(posedge clk) begin
    if (rst)                       chk_cnt <= '0;
    else if (start_norm || chain)  chk_cnt <= (SW+1)'(1);
    else if (done)                 chk_cnt <= '0;
    else if (chk_cnt != '0)        chk_cnt <= chk_cnt + (SW+1)'(1);
  end

  p_entry_len_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> (chk_cnt == (SW+1)'(DISP_CYC)));

  p_push_step_r3: assert property (@(posedge clk) disable iff (rst)
    stk_we && $past(stk_we) |-> (stk_addr == $past(stk_addr) + SP_W'(1)));

  p_clear_after_push_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(stk_we) && in_disp |-> flags_we && (flags_o == '0));

  p_ack_then_load_r5: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> done && pc_we && (pc_o[PC_W-1:DW] == '0));

  p_port_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(stk_we && stk_re));

  p_ret_wb_r6: assert property (@(posedge clk) disable iff (rst)
    ret_done |-> pc_we && flags_we && sp_we && !stk_re);

  p_reset_idle_r10: assert property (@(posedge clk)
    rst |=> !busy && !stk_we && !pc_we);
endmodule

// File: tb/irq_dispatch_seq_bench.sv
`timescale 1ns/1ps
module irq_dispatch_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        insn_done = 1'b0, reti_req = 1'b0, irq_req = 1'b0;
  logic [7:0]  irq_vec = 8'h00;
  logic [15:0] pc_r;
  logic [7:0]  f_r, sp_r, rdata_r;
  logic        busy, irq_ack, done, ret_done, pc_we, flags_we, sp_we, stk_we, stk_re;
  logic [15:0] pc_o;
  logic [7:0]  flags_o, sp_o, stk_addr, stk_wdata;
  logic [7:0]  mem [256];
  logic        pre_we = 1'b0;
  logic [15:0] pre_pc = 16'h0;
  logic [7:0]  pre_f = 8'h0, pre_sp = 8'h0;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  irq_dispatch_seq u_irq_dispatch_seq (
    .clk(clk), .rst(rst), .insn_done(insn_done), .reti_req(reti_req),
    .irq_req(irq_req), .irq_vec(irq_vec), .pc_i(pc_r), .flags_i(f_r),
    .sp_i(sp_r), .stk_rdata(rdata_r), .busy(busy), .irq_ack(irq_ack),
    .done(done), .ret_done(ret_done), .pc_we(pc_we), .pc_o(pc_o),
    .flags_we(flags_we), .flags_o(flags_o), .sp_we(sp_we), .sp_o(sp_o),
    .stk_we(stk_we), .stk_re(stk_re), .stk_addr(stk_addr), .stk_wdata(stk_wdata)
  );

  // processor register file and stack memory model
  always @(posedge clk) begin
    if (rst) begin
      pc_r <= 16'h0; f_r <= 8'h0; sp_r <= 8'h0;
    end else if (pre_we) begin
      pc_r <= pre_pc; f_r <= pre_f; sp_r <= pre_sp;
    end else begin
      if (pc_we)    pc_r <= pc_o;
      if (flags_we) f_r  <= flags_o;
      if (sp_we)    sp_r <= sp_o;
    end
    if (stk_we) mem[stk_addr] <= stk_wdata;
    if (stk_re) rdata_r <= mem[stk_addr];
  end

  function automatic logic [15:0] exp_entry_pc(input logic [7:0] v);
    return {8'h00, v};
  endfunction
  function automatic logic [7:0] exp_sp_after(input logic [7:0] sp);
    return sp + 8'd3;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic preload(input logic [15:0] pc, input logic [7:0] f, input logic [7:0] sp);
    @(negedge clk); pre_we = 1'b1; pre_pc = pc; pre_f = f; pre_sp = sp;
    @(negedge clk); pre_we = 1'b0;
  endtask

  // boundary strobe, then watch 24 cycles; cycle k is seen after k edges
  task automatic fire(input bit is_ret, input bit noise, output int t_done,
                      output int t_ret, output int t_ack, output int n_ack, output int n_busy);
    t_done = 0; t_ret = 0; t_ack = 0; n_ack = 0; n_busy = 0;
    @(negedge clk); insn_done = 1'b1; reti_req = is_ret;
    @(negedge clk); insn_done = 1'b0; reti_req = 1'b0;
    for (int k = 1; k <= 24; k++) begin
      if (done) t_done = k;
      if (ret_done) t_ret = k;
      if (irq_ack) begin n_ack++; t_ack = k; end
      if (busy) n_busy++;
      if (noise && (k == 5 || k == 9)) begin insn_done = 1'b1; reti_req = (k == 9); end
      else begin insn_done = 1'b0; reti_req = 1'b0; end
      @(negedge clk);
    end
    insn_done = 1'b0; reti_req = 1'b0;
  endtask

  task automatic do_entry(input logic [15:0] pc, input logic [7:0] f, input logic [7:0] sp,
                          input logic [7:0] v, input bit noise);
    int td, tr, ta, na, nb;
    preload(pc, f, sp);
    irq_vec = v; irq_req = 1'b1;
    fire(1'b0, noise, td, tr, ta, na, nb);
    irq_req = 1'b0;
    check("R1 entry started (busy cycles)", nb, 13);
    check("R2 done cycle", td, 13);
    check("R5 ack cycle", ta, 12);
    check("R5 ack count", na, 1);
    check("R3 push PC high", mem[sp], pc[15:8]);
    check("R3 push PC low", mem[sp + 8'd1], pc[7:0]);
    check("R3 push flags", mem[sp + 8'd2], f);
    check("R3 final SP", sp_r, exp_sp_after(sp));
    check("R4 flags cleared", f_r, 8'h00);
    check("R5 PC from vector", pc_r, exp_entry_pc(v));
    if (noise) check("R9 no return ran during entry", tr, 0);
  endtask

  task automatic do_return(input logic [15:0] pc, input logic [7:0] f, input logic [7:0] sp);
    int td, tr, ta, na, nb;
    fire(1'b1, 1'b0, td, tr, ta, na, nb);
    check("R6 ret_done cycle", tr, 4);
    check("R6 PC restored", pc_r, pc);
    check("R6 flags restored", f_r, f);
    check("R6 SP restored", sp_r, sp);
    check("R8 no chain without request", td, 0);
  endtask

  initial begin
    int td, tr, ta, na, nb;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10 busy after reset", busy, 0);
    check("R10 strobes after reset",
          {stk_we, stk_re, pc_we, flags_we, sp_we, irq_ack, done, ret_done}, 0);

    // R1 request without boundary strobe does nothing
    preload(16'h1234, 8'h01, 8'h40);
    irq_req = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 no start without boundary", busy, 0);
    irq_req = 1'b0;

    // R9 global enable clear blocks the request
    preload(16'h2345, 8'hFE, 8'h50);
    irq_req = 1'b1;
    fire(1'b0, 1'b0, td, tr, ta, na, nb);
    irq_req = 1'b0;
    check("R9 gie clear: no busy", nb, 0);
    check("R9 gie clear: PC kept", pc_r, 16'h2345);
    check("R9 gie clear: SP kept", sp_r, 8'h50);

    // directed entry/return, with SP wrapping past 255 and noise while busy
    do_entry(16'hBEEF, 8'h81, 8'hFE, 8'h04, 1'b1);
    do_return(16'hBEEF, 8'h81, 8'hFE);

    // R7 + R8: return and request together, ISR re-enabled interrupts
    do_entry(16'hA55A, 8'h03, 8'h10, 8'h0C, 1'b0);
    preload(16'h0C40, 8'h01, 8'h13);
    irq_vec = 8'h1C; irq_req = 1'b1;
    fire(1'b1, 1'b0, td, tr, ta, na, nb);
    irq_req = 1'b0;
    check("R7 return ran first", tr, 4);
    check("R8 chained done cycle", td, 17);
    check("R8 chained ack cycle", ta, 16);
    check("R8 busy without gap", nb, 17);
    check("R8 pushed restored PC high", mem[8'h10], 8'hA5);
    check("R8 pushed restored PC low", mem[8'h11], 8'h5A);
    check("R8 pushed restored flags", mem[8'h12], 8'h03);
    check("R8 new PC", pc_r, exp_entry_pc(8'h1C));
    check("R8 SP after chain", sp_r, 8'h13);
    check("R8 flags cleared", f_r, 8'h00);
    do_return(16'hA55A, 8'h03, 8'h10);

    // random frames
    for (int i = 0; i < 30; i++) begin
      logic [15:0] rp;
      logic [7:0] rf, rs, rv;
      rp = 16'($urandom());
      rf = 8'($urandom()) | 8'h01;
      rs = 8'($urandom());
      rv = 8'($urandom());
      do_entry(rp, rf, rs, rv, (i % 3) == 0);
      do_return(rp, rf, rs);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule